// File: doc/BRIEF.md
# Debug Instruction Transfer Chain

This block is the debug scan chain that lets an external debugger hand a 32-bit instruction word to a halted core. The chain is 33 bits long: one status bit followed by a 32-bit instruction field. The debugger fills it through the test access port while the chain is selected, and an update moves the instruction field into a write-only instruction register. The register's contents can never be shifted back out. Capturing the chain returns the core's Ready flag in the status position, so the debugger can poll whether the previous instruction has finished.

The instruction is not issued on update. It is issued when the TAP controller enters Run-Test/Idle, and only when three conditions hold together: the core's execute-enable control bit is set, the Ready flag was captured as 1, and the core's sticky precise-abort flag is clear. An issue produces a one-cycle strobe alongside the instruction word. The same issue clears the internal Ready flag, and the core's completion pulse sets it again. Execution itself lies outside this block and is modelled by the completion input.

All TAP qualifiers arrive as synchronous enables in the core clock domain.

Top module: `instr_xfer_chain`

## Requirements
- R1: After reset `issue_o` is 0, `instr_o` is 0, `tdo` is 0, and the internal Ready flag is 1, so the first capture returns 1 in the status position.
- R2: A capture with `chain_sel` high loads the Ready flag into status position 0, which appears on `tdo` one cycle later. The 32 instruction positions capture as zero, so the register's contents never show on `tdo`.
- R3: Each shift cycle with `chain_sel` high moves the chain one place toward `tdo`, least significant bit first. The first bit shifted in is the status bit, and its value is discarded. The next 32 bits are instruction bits 0 to 31.
- R4: An update with `chain_sel` high copies the 32 instruction bits into `instr_o`. With `chain_sel` low, capture, shift and update have no effect on `instr_o` or on the Ready flag.
- R5: On the first cycle of a Run-Test/Idle visit, an issue happens if `exec_en` is 1, the last capture saw Ready as 1, and `sticky_abort` is 0. `issue_o` is then high for exactly the following cycle, with `instr_o` holding the instruction.
- R6: With `exec_en` low, a Run-Test/Idle visit issues nothing and changes no state. A later visit with `exec_en` high still issues the same instruction.
- R7: With `sticky_abort` high, a Run-Test/Idle visit issues nothing and changes no state.
- R8: If the last capture saw Ready as 0, or no capture has happened since reset or since the last issue, a Run-Test/Idle visit issues nothing.
- R9: A visit held for many cycles produces one strobe only. A second visit with no new capture in between produces none.
- R10: An issue clears the Ready flag, and a one-cycle `instr_done` pulse sets it again. If `instr_done` arrives in the same cycle as an issue, the issue wins and Ready stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| chain_sel | input | 1 | This chain and the external-test instruction are selected |
| capture_dr | input | 1 | TAP in Capture-DR this cycle |
| shift_dr | input | 1 | TAP in Shift-DR this cycle |
| update_dr | input | 1 | TAP in Update-DR this cycle |
| rti | input | 1 | TAP in Run-Test/Idle (level) |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| exec_en | input | 1 | Execute-instruction enable control bit from the core |
| sticky_abort | input | 1 | Sticky precise-abort flag from the core |
| instr_done | input | 1 | One-cycle pulse when the core completes the issued instruction |
| instr_o | output | 32 | Instruction register contents |
| issue_o | output | 1 | One-cycle issue strobe |

## Verification
The issue and the core's completion pulse can both act on the Ready flag in the same cycle: the issue clears it and the completion sets it. The bench raises `instr_done` on the same clock edge where Run-Test/Idle is first seen with every issue condition met. It then captures the chain and expects a status bit of 0. A separate completion pulse afterwards must bring the status back to 1.

// File: rtl/ichain_pkg.sv
package ichain_pkg;
  localparam int unsigned DEF_INSTR_W = 32;
  localparam int unsigned STAT_POS    = 0;

  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } tap_qual_t;
endpackage

// File: rtl/ichain_shifter.sv
module ichain_shifter #(
  parameter int unsigned INSTR_W = ichain_pkg::DEF_INSTR_W,
  localparam int unsigned CHAIN_W = INSTR_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ichain_pkg::tap_qual_t q,
  input  logic                  ready_in,
  input  logic                  tdi,
  output logic                  tdo,
  output logic [INSTR_W-1:0]    field
);
  logic [CHAIN_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (q.capture) begin
      sr <= {{INSTR_W{1'b0}}, ready_in};
    end else if (q.shift) begin
      sr <= {tdi, sr[CHAIN_W-1:1]};
    end
  end

  assign tdo   = sr[ichain_pkg::STAT_POS];
  assign field = sr[CHAIN_W-1:1];
endmodule

// File: rtl/ichain_instr_reg.sv
module ichain_instr_reg #(
  parameter int unsigned INSTR_W = ichain_pkg::DEF_INSTR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [INSTR_W-1:0] d,
  output logic [INSTR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/ichain_issue_ctl.sv
module ichain_issue_ctl (
  input  logic clk,
  input  logic rst,
  input  logic capture,
  input  logic rti,
  input  logic exec_en,
  input  logic sticky_abort,
  input  logic instr_done,
  output logic ready_flag,
  output logic issue_o
);
  logic rti_d;
  logic cap_rdy;
  logic fire;

  assign fire = rti & ~rti_d & exec_en & cap_rdy & ~sticky_abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      rti_d      <= 1'b0;
      ready_flag <= 1'b1;
      cap_rdy    <= 1'b0;
      issue_o    <= 1'b0;
    end else begin
      rti_d   <= rti;
      issue_o <= fire;
      if (fire) begin
        ready_flag <= 1'b0;
        cap_rdy    <= 1'b0;
      end else begin
        if (instr_done) ready_flag <= 1'b1;
        if (capture)    cap_rdy    <= ready_flag;
      end
    end
  end
endmodule

// File: rtl/instr_xfer_chain.sv
module instr_xfer_chain #(
  parameter int unsigned INSTR_W = ichain_pkg::DEF_INSTR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               chain_sel,
  input  logic               capture_dr,
  input  logic               shift_dr,
  input  logic               update_dr,
  input  logic               rti,
  input  logic               tdi,
  output logic               tdo,
  input  logic               exec_en,
  input  logic               sticky_abort,
  input  logic               instr_done,
  output logic [INSTR_W-1:0] instr_o,
  output logic               issue_o
);
  ichain_pkg::tap_qual_t qual;
  logic [INSTR_W-1:0]    field;
  logic                  ready_flag;

  assign qual.capture = capture_dr & chain_sel;
  assign qual.shift   = shift_dr   & chain_sel;
  assign qual.update  = update_dr  & chain_sel;

  ichain_shifter #(.INSTR_W(INSTR_W)) u_shift (
    .clk(clk), .rst(rst), .q(qual), .ready_in(ready_flag),
    .tdi(tdi), .tdo(tdo), .field(field)
  );

  ichain_instr_reg #(.INSTR_W(INSTR_W)) u_ir (
    .clk(clk), .rst(rst), .load(qual.update), .d(field), .q(instr_o)
  );

  ichain_issue_ctl u_ctl (
    .clk(clk), .rst(rst), .capture(qual.capture), .rti(rti),
    .exec_en(exec_en), .sticky_abort(sticky_abort), .instr_done(instr_done),
    .ready_flag(ready_flag), .issue_o(issue_o)
  );
endmodule

// File: rtl/instr_xfer_chain_chk.sv
module instr_xfer_chain_chk #(
  parameter int unsigned INSTR_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               chain_sel,
  input logic               capture_dr,
  input logic               update_dr,
  input logic               rti,
  input logic               tdo,
  input logic               exec_en,
  input logic               sticky_abort,
  input logic [INSTR_W-1:0] instr_o,
  input logic               issue_o,
  input logic               ready_flag
);
  AST_TDO_STATUS: assert property (@(posedge clk) disable iff (rst)
    (capture_dr && chain_sel) |=> (tdo == $past(ready_flag))); // R2
  AST_INSTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(update_dr && chain_sel) |=> $stable(instr_o)); // R4
  AST_ISSUE_GATED: assert property (@(posedge clk) disable iff (rst)
    issue_o |-> ($past(exec_en) && !$past(sticky_abort) && $past(rti))); // R5
  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    issue_o |=> !issue_o); // R9
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    issue_o |-> !ready_flag); // R10
endmodule

bind instr_xfer_chain instr_xfer_chain_chk #(.INSTR_W(INSTR_W)) u_chk (
  .clk(clk), .rst(rst), .chain_sel(chain_sel), .capture_dr(capture_dr),
  .update_dr(update_dr), .rti(rti), .tdo(tdo), .exec_en(exec_en),
  .sticky_abort(sticky_abort), .instr_o(instr_o), .issue_o(issue_o),
  .ready_flag(ready_flag)
);

// File: tb/instr_xfer_chain_tb_top.sv
`timescale 1ns/1ps
module instr_xfer_chain_tb_top;
  localparam int W = 32;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chain_sel = 0, capture_dr = 0, shift_dr = 0, update_dr = 0, rti = 0, tdi = 0;
  logic exec_en = 0, sticky_abort = 0, instr_done = 0;
  logic tdo, issue_o;
  logic [W-1:0] instr_o;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  instr_xfer_chain #(.INSTR_W(W)) dut_i (
    .clk(clk), .rst(rst), .chain_sel(chain_sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .rti(rti), .tdi(tdi), .tdo(tdo),
    .exec_en(exec_en), .sticky_abort(sticky_abort), .instr_done(instr_done),
    .instr_o(instr_o), .issue_o(issue_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // capture, shift 33 bits (din[0] first), optional update; dout holds bits seen on tdo
  task automatic scan(input logic sel, input logic [W:0] din, input logic upd,
                      output logic [W:0] dout);
    @(negedge clk); chain_sel = sel; capture_dr = 1;
    @(negedge clk); capture_dr = 0;
    for (int i = 0; i <= W; i++) begin
      dout[i] = tdo; tdi = din[i]; shift_dr = 1;
      @(negedge clk);
    end
    shift_dr = 0; update_dr = upd;
    @(negedge clk); update_dr = 0; chain_sel = 0;
  endtask

  task automatic load(input logic [W-1:0] ins, input logic stat, output logic rdy_seen);
    logic [W:0] o;
    scan(1'b1, {ins, stat}, 1'b1, o);
    rdy_seen = o[0];
  endtask

  // rti for n cycles; returns number of strobes seen
  task automatic rti_visit(input int n, input logic done_now, output int cnt);
    cnt = 0;
    @(negedge clk); rti = 1; instr_done = done_now;
    @(negedge clk); instr_done = 0;
    for (int i = 0; i < n; i++) begin
      if (issue_o) cnt++;
      @(negedge clk);
    end
    rti = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); instr_done = 1;
    @(negedge clk); instr_done = 0;
  endtask

  task automatic read_ready(output logic r);
    @(negedge clk); chain_sel = 1; capture_dr = 1;
    @(negedge clk); capture_dr = 0; chain_sel = 0; r = tdo;
  endtask

  task automatic t_reset();
    logic r;
    chk("R1 issue", issue_o, 0);
    chk("R1 instr", instr_o, 0);
    chk("R1 tdo", tdo, 0);
    read_ready(r);
    chk("R1 ready", r, 1);
  endtask

  task automatic t_shift_load();
    logic [W:0] o;
    scan(1'b1, {32'hA5C3_0F71, 1'b0}, 1'b1, o);
    chk("R3 load", instr_o, 32'hA5C3_0F71);
    chk("R2 status", o[0], 1);
    chk("R2 field zero", o[W:1], 0);
    scan(1'b1, {32'h8000_0001, 1'b1}, 1'b1, o);
    chk("R3 order/status ignored", instr_o, 32'h8000_0001);
    chk("R2 no readback", o[W:1], 0);
  endtask

  task automatic t_unselected();
    logic [W:0] o;
    logic r;
    scan(1'b0, {32'hDEAD_BEEF, 1'b1}, 1'b1, o);
    chk("R4 unselected update", instr_o, 32'h8000_0001);
    read_ready(r);
    chk("R4 ready untouched", r, 1);
  endtask

  task automatic t_issue();
    logic rs; int c;
    exec_en = 1; sticky_abort = 0;
    load(32'h1234_5678, 1'b0, rs);
    rti = 0;
    @(negedge clk); rti = 1;
    @(negedge clk);
    chk("R5 strobe", issue_o, 1);
    chk("R5 instr at strobe", instr_o, 32'h1234_5678);
    c = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (issue_o) c++; end
    rti = 0;
    chk("R9 one per visit", c, 0);
    rti_visit(4, 1'b0, c);
    chk("R9 no reissue", c, 0);
    read_ready(rs);
    chk("R10 ready cleared", rs, 0);
    pulse_done();
    read_ready(rs);
    chk("R10 ready set by done", rs, 1);
  endtask

  task automatic t_exec_block();
    logic rs; int c;
    exec_en = 0;
    load(32'h0000_00E1, 1'b0, rs);
    rti_visit(3, 1'b0, c);
    chk("R6 no issue", c, 0);
    exec_en = 1;
    rti_visit(3, 1'b0, c);
    chk("R6 state kept", c, 1);
    pulse_done();
  endtask

  task automatic t_abort_block();
    logic rs; int c;
    sticky_abort = 1;
    load(32'h0000_00E2, 1'b0, rs);
    rti_visit(3, 1'b0, c);
    chk("R7 no issue", c, 0);
    sticky_abort = 0;
    rti_visit(3, 1'b0, c);
    chk("R7 state kept", c, 1);
    pulse_done();
  endtask

  task automatic t_not_ready();
    logic rs; int c;
    load(32'h0000_00E3, 1'b0, rs);
    rti_visit(2, 1'b0, c);
    load(32'h0000_00E4, 1'b0, rs);
    chk("R2 ready 0 captured", rs, 0);
    rti_visit(3, 1'b0, c);
    chk("R8 not ready blocks", c, 0);
    pulse_done();
    load(32'h0000_00E5, 1'b0, rs);
    rti_visit(3, 1'b0, c);
    chk("R8 issue after ready", c, 1);
    pulse_done();
  endtask

  task automatic t_collide();
    logic rs; int c;
    load(32'h0000_00E6, 1'b0, rs);
    rti_visit(3, 1'b1, c);
    chk("R10 collide issued", c, 1);
    read_ready(rs);
    chk("R10 issue wins over done", rs, 0);
    pulse_done();
    read_ready(rs);
    chk("R10 done later", rs, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_shift_load();
    t_unselected();
    t_issue();
    t_exec_block();
    t_abort_block();
    t_not_ready();
    t_collide();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule